// File: doc/BRIEF.md
# Decoder indirect register file with auto-incrementing pointer

This block is the host-facing register bank of an optical-disc data decoder. The host never addresses a register directly. It loads a 4-bit register pointer, then issues byte reads or byte writes. Each access goes to the register that the pointer currently selects. Reads and writes see two different banks of sixteen registers that share one index space. After most accesses the pointer steps to the next index, so the host can stream through a group of registers with back-to-back accesses.

Besides plain storage, some accesses have side effects. Writes can start a data transfer, stop it, acknowledge its end interrupt, or soft-reset the whole bank. Reads of the header and status group are tracked in a mask. When the complete set has been read, a final status read can raise a decode-ready code. A neighbouring data mover reports the end of a transfer through `xfer_last`. It also consumes the byte count, the address counter and the control bytes, which are driven out as ports.

Top module: `cdcr_regfile`

## Requirements
- R1: A read at pointer index 0x0 to 0xE moves the pointer to the next index. A read at 0xF leaves the pointer at 0xF.
- R2: A write at index 0x0 to 0x5 or 0x8 to 0xD moves the pointer forward by one. A write at 0x6 (trigger), 0x7 (acknowledge), 0xE (control byte 2) or 0xF (soft reset) leaves the pointer where it is.
- R3: When `ptr_wr_en` is high, the pointer takes `ptr_wr_data`. Any register read or write strobed in that same cycle is ignored. When a read and a write are strobed together without a pointer load, only the write takes effect.
- R4: After hardware reset the following hold:
  - The pointer is 0, `xfer_active` is 0 and `xfer_done` is 1.
  - Interface status is 0xFF.
  - The read bank returns, for indices 0..F: 00 FF 00 00 00 00 00 01 00 00 60 12 80 00 00 00. This gives header bytes 00 00 00 01, write address 4704 and status bytes 80 00 00 00.
  - Every writable register is 0.
- R5: Every 16-bit register is a little-endian byte pair, with the low byte at the lower index:
  - The byte count is written and read at 0x2/0x3.
  - The address counter is written at 0x4/0x5 and appears on `addr_ctr`.
  - The write address is written at 0x8/0x9 and read at 0xA/0xB.
  - The block pointer is written at 0xC/0xD and read at 0x8/0x9.
  - Control bytes 0, 1 and 2 are written at 0xA, 0xB and 0xE and appear on `ctl_o` as {ctrl2, ctrl1, ctrl0, interface control}.
  - The byte written at 0x0 appears on `subcode_o`.
- R6: Writing interface control (index 0x1) with bit 1 clear stops any transfer. The byte count becomes 0, `xfer_active` clears, and interface status bit 3 is set.
- R7: A write to the trigger register (index 0x6) has an effect only while interface-control bit 1 is set. It then clears interface status bit 3, sets `xfer_active` and clears `xfer_done`. With bit 1 clear the write is ignored. `xfer_active` high always implies status bit 3 low and `xfer_done` low.
- R8: A `xfer_last` pulse while a transfer is active does the following:
  - It clears `xfer_active`, sets `xfer_done` and sets interface status bit 3.
  - If interface-control bit 6 is set, it also clears interface status bit 6, the end interrupt flag.
- R9: A write to the acknowledge register (index 0x7) sets interface status bit 6.
- R10: Decode-ready tracking works as follows:
  - A read at index 0x1, 0x4 to 0x9 or 0xC to 0xE records that index in a tracking mask (required pattern 0x73F2).
  - A read at 0xF returns the current status byte 3 and sets interface status bit 5.
  - If that read happens with control-0 bit 7 and interface-control bit 5 set, and the mask is complete, status byte 3 then becomes 0x80.
- R11: A write at index 0xF returns every register, the tracking mask and the transfer state to their R4 values. The pointer and `xfer_done` are not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_wr_en | input | 1 | Load the register pointer |
| ptr_wr_data | input | 4 | New pointer value |
| reg_wr_en | input | 1 | Write strobe for the selected register |
| reg_wr_data | input | 8 | Write data |
| reg_rd_en | input | 1 | Read strobe for the selected register (side effects at the clock edge) |
| reg_rd_data | output | 8 | Contents of the read register the pointer selects |
| ptr_o | output | 4 | Current register pointer |
| xfer_last | input | 1 | End-of-transfer pulse from the data mover |
| xfer_active | output | 1 | A transfer is running |
| xfer_done | output | 1 | Last transfer has ended (cleared by a start) |
| ifstat_o | output | 8 | Interface status byte (active-low flags) |
| byte_cnt | output | 16 | Transfer byte count |
| addr_ctr | output | 16 | Transfer source address counter |
| wr_addr | output | 16 | Sector write address |
| ctl_o | output | 32 | {ctrl2, ctrl1, ctrl0, interface control} |
| subcode_o | output | 8 | Subcode output byte |

## Verification
The properties take for granted that the host raises at most one of the three access strobes in a cycle. The precedence rule in R3 is checked separately, where the bench drives a pointer load and a write together. The properties also assume that `xfer_last` is never pulsed in the same cycle as a register write. The stimulus follows this: every access is a single-cycle strobe separated from the next, and `xfer_last` is pulsed only while the host is idle. The scoreboard predicts each read byte from the requirement tables. Port-level checks follow the writes that have side effects.

// File: rtl/cdcr_pkg.sv
package cdcr_pkg;
  localparam int DATA_W    = 8;
  localparam int CNT_W     = 2 * DATA_W;
  localparam int IDX_W     = 4;
  localparam int REG_CNT   = 1 << IDX_W;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [IDX_W-1:0]  idx_t;

  // write bank
  localparam idx_t WR_SUBC  = 4'h0;
  localparam idx_t WR_IFC   = 4'h1;
  localparam idx_t WR_CNTL  = 4'h2;
  localparam idx_t WR_CNTH  = 4'h3;
  localparam idx_t WR_ACL   = 4'h4;
  localparam idx_t WR_ACH   = 4'h5;
  localparam idx_t WR_TRIG  = 4'h6;
  localparam idx_t WR_ACK   = 4'h7;
  localparam idx_t WR_WADL  = 4'h8;
  localparam idx_t WR_WADH  = 4'h9;
  localparam idx_t WR_CTL0  = 4'hA;
  localparam idx_t WR_CTL1  = 4'hB;
  localparam idx_t WR_BPL   = 4'hC;
  localparam idx_t WR_BPH   = 4'hD;
  localparam idx_t WR_CTL2  = 4'hE;
  localparam idx_t WR_SRST  = 4'hF;

  // read bank
  localparam idx_t RD_CMDIN = 4'h0;
  localparam idx_t RD_IFS   = 4'h1;
  localparam idx_t RD_CNTL  = 4'h2;
  localparam idx_t RD_CNTH  = 4'h3;
  localparam idx_t RD_HDR0  = 4'h4;
  localparam idx_t RD_BPL   = 4'h8;
  localparam idx_t RD_BPH   = 4'h9;
  localparam idx_t RD_WADL  = 4'hA;
  localparam idx_t RD_WADH  = 4'hB;
  localparam idx_t RD_ST0   = 4'hC;
  localparam idx_t RD_ST3   = 4'hF;

  // bit positions
  localparam int IFS_BUSY_N  = 3;
  localparam int IFS_DECI_N  = 5;
  localparam int IFS_ENDI_N  = 6;
  localparam int IFC_OUT_EN  = 1;
  localparam int IFC_DEC_IE  = 5;
  localparam int IFC_END_IE  = 6;
  localparam int CTL0_DEC_EN = 7;

  // reset contents
  localparam byte_t           IFS_RST    = 8'hFF;
  localparam logic [31:0]     HDR_RST    = 32'h0100_0000;
  localparam logic [CNT_W-1:0] WADDR_RST = 16'd4704;
  localparam logic [31:0]     STAT_RST   = 32'h0000_0080;
  localparam logic [REG_CNT-1:0] TRACK_NEED = 16'h73F2;
  localparam byte_t           ST3_READY  = 8'h80;
endpackage

// File: rtl/cdcr_pointer.sv
module cdcr_pointer
  import cdcr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  idx_t load_val,
  input  logic adv,
  output idx_t ptr
);
  idx_t ptr_n;
  logic ptr_en;

  always_comb begin
    ptr_en = load | adv;
    ptr_n  = load ? load_val : ptr + idx_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (ptr_en) ptr <= ptr_n;
  end
endmodule

// File: rtl/cdcr_xfer.sv
module cdcr_xfer
  import cdcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             wr_ifc,
  input  logic             wr_cntl,
  input  logic             wr_cnth,
  input  logic             wr_trig,
  input  logic             wr_ack,
  input  logic             rd_st3,
  input  logic             xfer_last,
  input  byte_t            wdata,
  output byte_t            ifctrl,
  output byte_t            ifstat,
  output logic [CNT_W-1:0] cnt,
  output logic             active,
  output logic             done
);
  byte_t            ifctrl_n, ifstat_n;
  logic [CNT_W-1:0] cnt_n;
  logic             active_n, done_n, upd_en;

  always_comb begin
    ifctrl_n = ifctrl;
    ifstat_n = ifstat;
    cnt_n    = cnt;
    active_n = active;
    done_n   = done;
    if (soft_rst) begin
      ifctrl_n = '0;
      ifstat_n = IFS_RST;
      cnt_n    = '0;
      active_n = 1'b0;
    end else begin
      if (xfer_last && active) begin
        active_n             = 1'b0;
        done_n               = 1'b1;
        ifstat_n[IFS_BUSY_N] = 1'b1;
        if (ifctrl[IFC_END_IE]) ifstat_n[IFS_ENDI_N] = 1'b0;
      end
      if (wr_ifc) begin
        ifctrl_n = wdata;
        if (!wdata[IFC_OUT_EN]) begin
          cnt_n                = '0;
          active_n             = 1'b0;
          ifstat_n[IFS_BUSY_N] = 1'b1;
        end
      end
      if (wr_cntl) cnt_n[DATA_W-1:0]     = wdata;
      if (wr_cnth) cnt_n[CNT_W-1:DATA_W] = wdata;
      if (wr_trig && ifctrl[IFC_OUT_EN]) begin
        ifstat_n[IFS_BUSY_N] = 1'b0;
        active_n             = 1'b1;
        done_n               = 1'b0;
      end
      if (wr_ack) ifstat_n[IFS_ENDI_N] = 1'b1;
      if (rd_st3) ifstat_n[IFS_DECI_N] = 1'b1;
    end
    upd_en = soft_rst | wr_ifc | wr_cntl | wr_cnth | wr_trig | wr_ack |
             rd_st3 | xfer_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifctrl <= '0;
      ifstat <= IFS_RST;
      cnt    <= '0;
      active <= 1'b0;
      done   <= 1'b1;
    end else if (upd_en) begin
      ifctrl <= ifctrl_n;
      ifstat <= ifstat_n;
      cnt    <= cnt_n;
      active <= active_n;
      done   <= done_n;
    end
  end
endmodule

// File: rtl/cdcr_track.sv
module cdcr_track
  import cdcr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  soft_rst,
  input  logic  rd_hit,
  input  idx_t  rd_idx,
  input  logic  dec_en,
  output byte_t st3
);
  logic [REG_CNT-1:0] seen;
  logic               complete;
  byte_t              st3_n;
  logic               st3_en;

  for (genvar gi = 0; gi < REG_CNT; gi++) begin : g_seen
    if (TRACK_NEED[gi]) begin : g_bit
      logic hit_n, hit_en;
      always_comb begin
        hit_en = soft_rst | (rd_hit && rd_idx == idx_t'(gi));
        hit_n  = ~soft_rst;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      seen[gi] <= 1'b0;
        else if (hit_en) seen[gi] <= hit_n;
      end
    end else begin : g_none
      assign seen[gi] = 1'b0;
    end
  end

  always_comb begin
    complete = ((seen | ~TRACK_NEED) == '1);
    st3_en   = soft_rst | (rd_hit && rd_idx == RD_ST3 && dec_en && complete);
    st3_n    = soft_rst ? STAT_RST[31:24] : ST3_READY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st3 <= STAT_RST[31:24];
    else if (st3_en) st3 <= st3_n;
  end
endmodule

// File: rtl/cdcr_regfile.sv
module cdcr_regfile
  import cdcr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ptr_wr_en,
  input  logic [3:0]  ptr_wr_data,
  input  logic        reg_wr_en,
  input  logic [7:0]  reg_wr_data,
  input  logic        reg_rd_en,
  output logic [7:0]  reg_rd_data,
  output logic [3:0]  ptr_o,
  input  logic        xfer_last,
  output logic        xfer_active,
  output logic        xfer_done,
  output logic [7:0]  ifstat_o,
  output logic [15:0] byte_cnt,
  output logic [15:0] addr_ctr,
  output logic [15:0] wr_addr,
  output logic [31:0] ctl_o,
  output logic [7:0]  subcode_o
);
  idx_t  ptr;
  logic  acc_wr, acc_rd, wr_hold, adv;
  logic  [REG_CNT-1:0] wsel;
  logic  soft_rst;
  byte_t ifctrl, st3;
  byte_t ctl0, ctl1, ctl2, subc;
  logic [CNT_W-1:0] acnt, waddr, bptr;
  byte_t rd_bank [REG_CNT];

  // access qualification and pointer stepping
  always_comb begin
    acc_wr  = reg_wr_en & ~ptr_wr_en;
    acc_rd  = reg_rd_en & ~ptr_wr_en & ~reg_wr_en;
    wr_hold = (ptr == WR_TRIG) | (ptr == WR_ACK) |
              (ptr == WR_CTL2) | (ptr == WR_SRST);
    adv     = (acc_wr & ~wr_hold) | (acc_rd & (ptr != RD_ST3));
    for (int i = 0; i < REG_CNT; i++) wsel[i] = acc_wr && (ptr == idx_t'(i));
    soft_rst = wsel[WR_SRST];
  end

  cdcr_pointer u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_wr_en),
    .load_val (ptr_wr_data),
    .adv      (adv),
    .ptr      (ptr)
  );

  cdcr_xfer u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .wr_ifc    (wsel[WR_IFC]),
    .wr_cntl   (wsel[WR_CNTL]),
    .wr_cnth   (wsel[WR_CNTH]),
    .wr_trig   (wsel[WR_TRIG]),
    .wr_ack    (wsel[WR_ACK]),
    .rd_st3    (acc_rd && ptr == RD_ST3),
    .xfer_last (xfer_last),
    .wdata     (reg_wr_data),
    .ifctrl    (ifctrl),
    .ifstat    (ifstat_o),
    .cnt       (byte_cnt),
    .active    (xfer_active),
    .done      (xfer_done)
  );

  cdcr_track u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .rd_hit   (acc_rd),
    .rd_idx   (ptr),
    .dec_en   (ctl0[CTL0_DEC_EN] & ifctrl[IFC_DEC_IE]),
    .st3      (st3)
  );

  // plain storage: next state
  byte_t ctl0_n, ctl1_n, ctl2_n, subc_n;
  logic [CNT_W-1:0] acnt_n, waddr_n, bptr_n;
  logic store_en;

  always_comb begin
    ctl0_n  = ctl0;  ctl1_n = ctl1;  ctl2_n = ctl2;  subc_n = subc;
    acnt_n  = acnt;  waddr_n = waddr; bptr_n = bptr;
    if (soft_rst) begin
      ctl0_n = '0; ctl1_n = '0; ctl2_n = '0; subc_n = '0;
      acnt_n = '0; waddr_n = WADDR_RST; bptr_n = '0;
    end else begin
      if (wsel[WR_SUBC]) subc_n = reg_wr_data;
      if (wsel[WR_ACL])  acnt_n[DATA_W-1:0]      = reg_wr_data;
      if (wsel[WR_ACH])  acnt_n[CNT_W-1:DATA_W]  = reg_wr_data;
      if (wsel[WR_WADL]) waddr_n[DATA_W-1:0]     = reg_wr_data;
      if (wsel[WR_WADH]) waddr_n[CNT_W-1:DATA_W] = reg_wr_data;
      if (wsel[WR_CTL0]) ctl0_n = reg_wr_data;
      if (wsel[WR_CTL1]) ctl1_n = reg_wr_data;
      if (wsel[WR_BPL])  bptr_n[DATA_W-1:0]      = reg_wr_data;
      if (wsel[WR_BPH])  bptr_n[CNT_W-1:DATA_W]  = reg_wr_data;
      if (wsel[WR_CTL2]) ctl2_n = reg_wr_data;
    end
    store_en = acc_wr;
  end

  // plain storage: registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl0 <= '0; ctl1 <= '0; ctl2 <= '0; subc <= '0;
      acnt <= '0; waddr <= WADDR_RST; bptr <= '0;
    end else if (store_en) begin
      ctl0 <= ctl0_n; ctl1 <= ctl1_n; ctl2 <= ctl2_n; subc <= subc_n;
      acnt <= acnt_n; waddr <= waddr_n; bptr <= bptr_n;
    end
  end

  // read bank
  always_comb begin
    rd_bank[RD_CMDIN] = '0;
    rd_bank[RD_IFS]   = ifstat_o;
    rd_bank[RD_CNTL]  = byte_cnt[DATA_W-1:0];
    rd_bank[RD_CNTH]  = byte_cnt[CNT_W-1:DATA_W];
    for (int i = 0; i < 4; i++) begin
      rd_bank[RD_HDR0 + idx_t'(i)] = HDR_RST[i*DATA_W +: DATA_W];
    end
    rd_bank[RD_BPL]   = bptr[DATA_W-1:0];
    rd_bank[RD_BPH]   = bptr[CNT_W-1:DATA_W];
    rd_bank[RD_WADL]  = waddr[DATA_W-1:0];
    rd_bank[RD_WADH]  = waddr[CNT_W-1:DATA_W];
    for (int i = 0; i < 3; i++) begin
      rd_bank[RD_ST0 + idx_t'(i)] = STAT_RST[i*DATA_W +: DATA_W];
    end
    rd_bank[RD_ST3]   = st3;
  end

  assign reg_rd_data = rd_bank[ptr];
  assign ptr_o       = ptr;
  assign addr_ctr    = acnt;
  assign wr_addr     = waddr;
  assign ctl_o       = {ctl2, ctl1, ctl0, ifctrl};
  assign subcode_o   = subc;
endmodule

// File: rtl/cdcr_regfile_chk.sv
module cdcr_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ptr_wr_en,
  input logic [3:0] ptr_wr_data,
  input logic       reg_wr_en,
  input logic [7:0] reg_wr_data,
  input logic       reg_rd_en,
  input logic [3:0] ptr_o,
  input logic       xfer_active,
  input logic       xfer_done,
  input logic [7:0] ifstat_o
);
  logic rd_only, wr_only;
  assign rd_only = reg_rd_en && !reg_wr_en && !ptr_wr_en;
  assign wr_only = reg_wr_en && !ptr_wr_en;

  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_only && ptr_o != 4'hF |=> ptr_o == $past(ptr_o) + 4'd1); // R1
  AST_RD_STICK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_only && ptr_o == 4'hF |=> ptr_o == 4'hF); // R1
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_only && (ptr_o == 4'h6 || ptr_o == 4'h7 || ptr_o == 4'hE || ptr_o == 4'hF)
    |=> $stable(ptr_o)); // R2
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr_en |=> ptr_o == $past(ptr_wr_data)); // R3
  AST_STOP_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_only && ptr_o == 4'h1 && !reg_wr_data[1] |=> !xfer_active && ifstat_o[3]); // R6
  AST_BUSY_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_active |-> !ifstat_o[3] && !xfer_done); // R7
  AST_ACK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_only && ptr_o == 4'h7 |=> ifstat_o[6]); // R9
endmodule

bind cdcr_regfile cdcr_regfile_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ptr_wr_en   (ptr_wr_en),
  .ptr_wr_data (ptr_wr_data),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_data (reg_wr_data),
  .reg_rd_en   (reg_rd_en),
  .ptr_o       (ptr_o),
  .xfer_active (xfer_active),
  .xfer_done   (xfer_done),
  .ifstat_o    (ifstat_o)
);

// File: tb/cdcr_regfile_tb.sv
module cdcr_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ptr_wr_en, reg_wr_en, reg_rd_en, xfer_last;
  logic [3:0]  ptr_wr_data;
  logic [7:0]  reg_wr_data;
  logic [7:0]  reg_rd_data, ifstat_o, subcode_o;
  logic [3:0]  ptr_o;
  logic        xfer_active, xfer_done;
  logic [15:0] byte_cnt, addr_ctr, wr_addr;
  logic [31:0] ctl_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #5 clk = ~clk;

  cdcr_regfile u_dut (
    .clk(clk), .rst_n(rst_n),
    .ptr_wr_en(ptr_wr_en), .ptr_wr_data(ptr_wr_data),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data),
    .ptr_o(ptr_o), .xfer_last(xfer_last),
    .xfer_active(xfer_active), .xfer_done(xfer_done),
    .ifstat_o(ifstat_o), .byte_cnt(byte_cnt), .addr_ctr(addr_ctr),
    .wr_addr(wr_addr), .ctl_o(ctl_o), .subcode_o(subcode_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver tasks: called just after a falling edge
  task automatic setp(input logic [3:0] p);
    ptr_wr_en = 1'b1; ptr_wr_data = p;
    @(negedge clk);
    ptr_wr_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr_en = 1'b1; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] e, input string tag);
    q_exp.push_back(e);
    q_tag.push_back(tag);
    reg_rd_en = 1'b1;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  // monitor: compares read data with scoreboard
  initial begin
    logic [7:0] e;
    string t;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n === 1'b1 && reg_rd_en && !reg_wr_en && !ptr_wr_en) begin
        if (q_exp.size() == 0) check("monitor unexpected read", 32'd1, 32'd0);
        else begin
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          check(t, {24'd0, reg_rd_data}, {24'd0, e});
        end
      end
    end
  end

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ptr_wr_en = 0; reg_wr_en = 0; reg_rd_en = 0; xfer_last = 0;
    ptr_wr_data = '0; reg_wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 reset state
    check("R4 ptr", {28'd0, ptr_o}, 32'd0);
    check("R4 active", {31'd0, xfer_active}, 32'd0);
    check("R4 done", {31'd0, xfer_done}, 32'd1);
    check("R4 ifstat", {24'd0, ifstat_o}, 32'hFF);
    check("R4 ctl", ctl_o, 32'd0);
    check("R4 addr", {16'd0, addr_ctr}, 32'd0);
    rd(8'h00, "R4 rd0");  rd(8'hFF, "R4 rd1");  rd(8'h00, "R4 rd2");  rd(8'h00, "R4 rd3");
    rd(8'h00, "R4 rd4");  rd(8'h00, "R4 rd5");  rd(8'h00, "R4 rd6");  rd(8'h01, "R4 rd7");
    rd(8'h00, "R4 rd8");  rd(8'h00, "R4 rd9");  rd(8'h60, "R4 rdA");  rd(8'h12, "R4 rdB");
    rd(8'h80, "R4 rdC");  rd(8'h00, "R4 rdD");  rd(8'h00, "R4 rdE");  rd(8'h00, "R4 rdF");
    check("R1 ptr stops at F", {28'd0, ptr_o}, 32'hF);
    rd(8'h00, "R1 reread F");
    check("R1 ptr held at F", {28'd0, ptr_o}, 32'hF);

    // R5 lower-group writes and R7 start
    setp(4'h0);
    wr(8'hAA); wr(8'h62); wr(8'h34); wr(8'h12); wr(8'hCD); wr(8'hAB);
    check("R2 ptr after 0..5", {28'd0, ptr_o}, 32'h6);
    check("R5 addr_ctr", {16'd0, addr_ctr}, 32'hABCD);
    check("R5 byte_cnt", {16'd0, byte_cnt}, 32'h1234);
    check("R5 subcode", {24'd0, subcode_o}, 32'hAA);
    wr(8'h00);
    check("R2 trigger holds ptr", {28'd0, ptr_o}, 32'h6);
    check("R7 active", {31'd0, xfer_active}, 32'd1);
    check("R7 done cleared", {31'd0, xfer_done}, 32'd0);
    check("R7 ifstat", {24'd0, ifstat_o}, 32'hF7);

    // R3 pointer load beats a write to interface control
    setp(4'h1);
    ptr_wr_en = 1'b1; ptr_wr_data = 4'h3; reg_wr_en = 1'b1; reg_wr_data = 8'h00;
    @(negedge clk);
    ptr_wr_en = 1'b0; reg_wr_en = 1'b0;
    check("R3 ptr loaded", {28'd0, ptr_o}, 32'h3);
    check("R3 write ignored", {31'd0, xfer_active}, 32'd1);

    setp(4'h2);
    rd(8'h34, "R5 cnt low"); rd(8'h12, "R5 cnt high");

    // R8 end of transfer
    xfer_last = 1'b1; @(negedge clk); xfer_last = 1'b0;
    check("R8 active", {31'd0, xfer_active}, 32'd0);
    check("R8 done", {31'd0, xfer_done}, 32'd1);
    check("R8 ifstat", {24'd0, ifstat_o}, 32'hBF);

    // R9 acknowledge
    setp(4'h7); wr(8'h00);
    check("R9 ifstat", {24'd0, ifstat_o}, 32'hFF);
    check("R2 ack holds ptr", {28'd0, ptr_o}, 32'h7);

    // R5 upper-group writes
    setp(4'h8);
    wr(8'h78); wr(8'h56); wr(8'h80); wr(8'h00); wr(8'h22); wr(8'h11);
    check("R2 ptr after 8..D", {28'd0, ptr_o}, 32'hE);
    wr(8'h05); wr(8'h05);
    check("R2 ctrl2 holds ptr", {28'd0, ptr_o}, 32'hE);
    check("R5 ctl_o", ctl_o, 32'h0500_8062);
    check("R5 wr_addr", {16'd0, wr_addr}, 32'h5678);
    setp(4'h8);
    rd(8'h22, "R5 bp low"); rd(8'h11, "R5 bp high");
    rd(8'h78, "R5 wa low"); rd(8'h56, "R5 wa high");

    // R11 soft reset during a transfer
    setp(4'h6); wr(8'h00);
    check("R7 restart", {31'd0, xfer_active}, 32'd1);
    setp(4'hF); wr(8'h00);
    check("R11 ptr kept", {28'd0, ptr_o}, 32'hF);
    check("R11 active", {31'd0, xfer_active}, 32'd0);
    check("R11 done kept", {31'd0, xfer_done}, 32'd0);
    check("R11 ifstat", {24'd0, ifstat_o}, 32'hFF);
    check("R11 ctl", ctl_o, 32'd0);
    check("R11 addr", {16'd0, addr_ctr}, 32'd0);
    check("R11 cnt", {16'd0, byte_cnt}, 32'd0);
    check("R11 subcode", {24'd0, subcode_o}, 32'd0);
    setp(4'hA);
    rd(8'h60, "R11 wa low"); rd(8'h12, "R11 wa high");

    // R6 stop
    setp(4'h1); wr(8'h02); wr(8'h10); wr(8'h02);
    setp(4'h6); wr(8'h00);
    check("R6 pre active", {31'd0, xfer_active}, 32'd1);
    setp(4'h1); wr(8'h20);
    check("R6 active", {31'd0, xfer_active}, 32'd0);
    check("R6 ifstat", {24'd0, ifstat_o}, 32'hFF);
    check("R6 cnt", {16'd0, byte_cnt}, 32'd0);
    rd(8'h00, "R6 cnt low"); rd(8'h00, "R6 cnt high");

    // R7 trigger ignored without enable
    setp(4'h6); wr(8'h00);
    check("R7 ignored active", {31'd0, xfer_active}, 32'd0);
    check("R7 ignored ifstat", {24'd0, ifstat_o}, 32'hFF);

    // R10 decode-ready tracking
    setp(4'hA); wr(8'h80);
    setp(4'h1); rd(8'hFF, "R10 ifstat");
    setp(4'h4);
    rd(8'h00, "R10 hdr0"); rd(8'h00, "R10 hdr1"); rd(8'h00, "R10 hdr2"); rd(8'h01, "R10 hdr3");
    rd(8'h00, "R10 bp low"); rd(8'h00, "R10 bp high");
    setp(4'hF);
    rd(8'h00, "R10 incomplete"); rd(8'h00, "R10 still incomplete");
    setp(4'hC);
    rd(8'h80, "R10 st0"); rd(8'h00, "R10 st1"); rd(8'h00, "R10 st2");
    rd(8'h00, "R10 st3 old value");
    rd(8'h80, "R10 st3 ready");
    check("R10 ptr", {28'd0, ptr_o}, 32'hF);
    check("R10 ifstat bit5", {31'd0, ifstat_o[5]}, 32'd1);

    repeat (2) @(negedge clk);
    check("scoreboard drained", q_exp.size(), 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule